// File: doc/BRIEF.md
# Pointer-Selected Working Register File

This block holds sixteen working registers for a processor datapath. One of them is the active register, chosen by a small pointer rather than by an address in the instruction. Every result the ALU produces lands in the active register. The block also keeps the ALU status flags next to the registers, together with two flag bits that software can set freely.

A control field can make the pointer step up or down by one after each ALU result. The step wraps inside an aligned window of 2, 4, 8 or 16 registers, so a routine can rotate through a small group of registers without spending instructions on pointer upkeep. Explicit writes can load the pointer, the control field, any register by index and the general flags. A separate read port returns any register by index. The active register value, the pointer and all flags come straight from registers, so none of them depends combinationally on the inputs.

Top module: `ptr_acc_file`

## Requirements
- R1: While reset is held, and on the first clock after it, the pointer reads 0, the control field is 0 (no stepping, 2-register window), and every flag (carry, zero, sign, equal, overflow and both general flags) reads 0.
- R2: When `alu_we` is high, `alu_result` is written into the register that the pointer selects before any step in that cycle. If an explicit register write targets the same index in the same cycle, the ALU value is the one kept. An explicit write to a different index in that cycle still takes effect.
- R3: `acc_q` shows the register selected by the pointer one clock after any change to the pointer or to the contents of that register.
- R4: Control bits [1:0] choose the step: 0 holds, 1 increments, 2 decrements, 3 holds. Bits [3:2] choose the window: 0 gives 2 registers, 1 gives 4, 2 gives 8, 3 gives 16. With mode 1, each ALU result moves the pointer up by one and wraps from the top of its window to the window's base.
- R5: With mode 2, each ALU result moves the pointer down by one and wraps from the window's base to its top.
- R6: A step never changes the pointer bits above the selected window.
- R7: A pointer write (`ptr_we`) in the same cycle as an ALU result sets the pointer to `ptr_wdata`, and no step takes place.
- R8: On an ALU result, `alu_fmask` bit 0 loads carry from `alu_c`, bit 1 loads sign from `alu_s`, bit 2 loads equal from `alu_e`, and bit 3 loads overflow from `alu_ov`. Flags whose mask bit is clear, and all flags in cycles without an ALU result, keep their value.
- R9: `flag_z` is 1 exactly when the register shown on `acc_q` is zero. It updates in the same cycle as `acc_q`, whether the cause is an ALU result, an explicit write or a pointer change.
- R10: `gpf_we` loads the two general flags from `gpf_wdata`. ALU results never change them.
- R11: `rd_data` returns the register at `rd_addr` one clock later. It gives the contents from before any write in that same cycle.
- R12: The pointer changes only on a pointer write or an ALU result. A control write in the same cycle as an ALU result affects later results only; the step in that cycle uses the old control value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alu_we | input | 1 | ALU result valid this cycle |
| alu_result | input | DATA_W | Value written into the active register |
| alu_fmask | input | 4 | Which ALU flags to load: [0] carry, [1] sign, [2] equal, [3] overflow |
| alu_c | input | 1 | Carry value from the ALU |
| alu_s | input | 1 | Sign value from the ALU |
| alu_e | input | 1 | Equal value from the ALU |
| alu_ov | input | 1 | Overflow value from the ALU |
| ptr_we | input | 1 | Load the pointer |
| ptr_wdata | input | PTR_W | New pointer value |
| ctl_we | input | 1 | Load the control field |
| ctl_wdata | input | 4 | [1:0] step mode, [3:2] window select |
| reg_we | input | 1 | Explicit register write |
| reg_waddr | input | PTR_W | Index of the explicit write |
| reg_wdata | input | DATA_W | Data of the explicit write |
| rd_addr | input | PTR_W | Index for the read port |
| gpf_we | input | 1 | Load the general flags |
| gpf_wdata | input | 2 | New general flag values |
| acc_q | output | DATA_W | Active register value |
| ptr_q | output | PTR_W | Current pointer |
| rd_data | output | DATA_W | Read port data |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag of the active register |
| flag_s | output | 1 | Sign flag |
| flag_e | output | 1 | Equal flag |
| flag_ov | output | 1 | Overflow flag |
| flag_gp | output | 2 | General flags |

## Verification
The properties assume that every write strobe is a clean 0 or 1 on each rising edge. They also assume that ALU results and pointer writes come as single-cycle pulses, so that the `$past` of the inputs describes exactly the action that moved the pointer or the flags. The register contents start undefined, so nothing checks `acc_q` or the zero flag until the stimulus has written all sixteen registers. Inputs change only on falling edges, and the stimulus pairs pointer, control and register writes with ALU results on purpose, so that each priority rule meets the case it decides.

// File: rtl/acc_file_pkg.sv
package acc_file_pkg;

  // Step behaviour applied to the pointer after each ALU result
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2,
    STEP_KEEP = 2'd3
  } step_mode_e;

  localparam int CTL_W        = 4;
  localparam int NUM_ALU_FLAG = 4;
  localparam int FM_CY        = 0;
  localparam int FM_SG        = 1;
  localparam int FM_EQ        = 2;
  localparam int FM_OV        = 3;

  // wrap_sel: window of 2 << wrap_sel registers
  typedef struct packed {
    logic [1:0] wrap_sel;
    step_mode_e mode;
  } acc_ctl_t;

  typedef struct packed {
    logic [1:0] gp;
    logic       ov;
    logic       eq;
    logic       sg;
    logic       zr;
    logic       cy;
  } acc_flags_t;

endpackage

// File: rtl/acc_ptr_unit.sv
module acc_ptr_unit
  import acc_file_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alu_we,
  input  logic             ptr_we,
  input  logic [PTR_W-1:0] ptr_wdata,
  input  logic             ctl_we,
  input  acc_ctl_t         ctl_wdata,
  output logic [PTR_W-1:0] ptr_q,
  output logic [PTR_W-1:0] ptr_nxt,
  output acc_ctl_t         ctl_q
);

  logic [PTR_W-1:0] wrap_mask;
  logic [PTR_W-1:0] ptr_up;
  logic [PTR_W-1:0] ptr_dn;
  logic [PTR_W-1:0] ptr_stepped;

  // Low bits covered by the window; windows wider than the file saturate
  always_comb begin
    for (int i = 0; i < PTR_W; i++) begin
      wrap_mask[i] = (i <= int'(ctl_q.wrap_sel));
    end
  end

  assign ptr_up = (ptr_q & ~wrap_mask) | ((ptr_q + PTR_W'(1)) & wrap_mask);
  assign ptr_dn = (ptr_q & ~wrap_mask) | ((ptr_q - PTR_W'(1)) & wrap_mask);

  always_comb begin
    case (ctl_q.mode)
      STEP_INC: ptr_stepped = ptr_up;
      STEP_DEC: ptr_stepped = ptr_dn;
      default:  ptr_stepped = ptr_q;
    endcase
  end

  // Explicit load beats the auto-step
  always_comb begin
    if (ptr_we)      ptr_nxt = ptr_wdata;
    else if (alu_we) ptr_nxt = ptr_stepped;
    else             ptr_nxt = ptr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      ctl_q <= '0;
    end else begin
      ptr_q <= ptr_nxt;
      if (ctl_we) ctl_q <= ctl_wdata;
    end
  end

endmodule

// File: rtl/acc_regfile.sv
module acc_regfile #(
  parameter int NUM_ACC = 16,
  parameter int DATA_W  = 16,
  parameter int PTR_W   = 4
) (
  input  logic              clk,
  input  logic              alu_en,
  input  logic [PTR_W-1:0]  alu_idx,
  input  logic [DATA_W-1:0] alu_data,
  input  logic              ext_en,
  input  logic [PTR_W-1:0]  ext_idx,
  input  logic [DATA_W-1:0] ext_data,
  input  logic [PTR_W-1:0]  peek_idx,
  output logic [DATA_W-1:0] peek_data,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_q
);

  logic [DATA_W-1:0] mem [NUM_ACC];

  // ALU write is issued last so it wins on an index collision
  always_ff @(posedge clk) begin
    if (ext_en) mem[ext_idx] <= ext_data;
    if (alu_en) mem[alu_idx] <= alu_data;
    rd_q <= mem[rd_idx];
  end

  // Value the peeked entry will hold after this edge
  always_comb begin
    if (alu_en && (alu_idx == peek_idx))      peek_data = alu_data;
    else if (ext_en && (ext_idx == peek_idx)) peek_data = ext_data;
    else                                      peek_data = mem[peek_idx];
  end

endmodule

// File: rtl/acc_flag_unit.sv
module acc_flag_unit
  import acc_file_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    alu_we,
  input  logic [NUM_ALU_FLAG-1:0] fmask,
  input  logic [NUM_ALU_FLAG-1:0] fval,
  input  logic                    gpf_we,
  input  logic [1:0]              gpf_wdata,
  input  logic                    zero_nxt,
  output acc_flags_t              flags_q
);

  logic [NUM_ALU_FLAG-1:0] alu_flag_q;
  logic [1:0]              gp_q;
  logic                    zero_q;

  for (genvar g = 0; g < NUM_ALU_FLAG; g++) begin : g_flag
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst)                       bit_q <= 1'b0;
      else if (alu_we && fmask[g])   bit_q <= fval[g];
    end
    assign alu_flag_q[g] = bit_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gp_q   <= '0;
      zero_q <= 1'b0;
    end else begin
      zero_q <= zero_nxt;
      if (gpf_we) gp_q <= gpf_wdata;
    end
  end

  assign flags_q = '{gp: gp_q,
                     ov: alu_flag_q[FM_OV],
                     eq: alu_flag_q[FM_EQ],
                     sg: alu_flag_q[FM_SG],
                     zr: zero_q,
                     cy: alu_flag_q[FM_CY]};

endmodule

// File: rtl/ptr_acc_file.sv
module ptr_acc_file
  import acc_file_pkg::*;
#(
  parameter  int NUM_ACC = 16,
  parameter  int DATA_W  = 16,
  localparam int PTR_W   = $clog2(NUM_ACC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alu_we,
  input  logic [DATA_W-1:0] alu_result,
  input  logic [3:0]        alu_fmask,
  input  logic              alu_c,
  input  logic              alu_s,
  input  logic              alu_e,
  input  logic              alu_ov,
  input  logic              ptr_we,
  input  logic [PTR_W-1:0]  ptr_wdata,
  input  logic              ctl_we,
  input  logic [3:0]        ctl_wdata,
  input  logic              reg_we,
  input  logic [PTR_W-1:0]  reg_waddr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [PTR_W-1:0]  rd_addr,
  input  logic              gpf_we,
  input  logic [1:0]        gpf_wdata,
  output logic [DATA_W-1:0] acc_q,
  output logic [PTR_W-1:0]  ptr_q,
  output logic [DATA_W-1:0] rd_data,
  output logic              flag_c,
  output logic              flag_z,
  output logic              flag_s,
  output logic              flag_e,
  output logic              flag_ov,
  output logic [1:0]        flag_gp
);

  acc_ctl_t          ctl_q;
  logic [PTR_W-1:0]  ptr_nxt;
  logic [DATA_W-1:0] peek_data;
  acc_flags_t        flags_q;
  logic [1:0]        ctl_mode_w;
  logic [1:0]        ctl_wrap_w;

  acc_ptr_unit #(.PTR_W(PTR_W)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .alu_we    (alu_we),
    .ptr_we    (ptr_we),
    .ptr_wdata (ptr_wdata),
    .ctl_we    (ctl_we),
    .ctl_wdata (acc_ctl_t'(ctl_wdata)),
    .ptr_q     (ptr_q),
    .ptr_nxt   (ptr_nxt),
    .ctl_q     (ctl_q)
  );

  acc_regfile #(.NUM_ACC(NUM_ACC), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_rf (
    .clk       (clk),
    .alu_en    (alu_we),
    .alu_idx   (ptr_q),
    .alu_data  (alu_result),
    .ext_en    (reg_we),
    .ext_idx   (reg_waddr),
    .ext_data  (reg_wdata),
    .peek_idx  (ptr_nxt),
    .peek_data (peek_data),
    .rd_idx    (rd_addr),
    .rd_q      (rd_data)
  );

  acc_flag_unit u_flg (
    .clk       (clk),
    .rst       (rst),
    .alu_we    (alu_we),
    .fmask     (alu_fmask),
    .fval      ({alu_ov, alu_e, alu_s, alu_c}),
    .gpf_we    (gpf_we),
    .gpf_wdata (gpf_wdata),
    .zero_nxt  (peek_data == '0),
    .flags_q   (flags_q)
  );

  // Active register mirror, refreshed with the post-edge value
  always_ff @(posedge clk) begin
    acc_q <= peek_data;
  end

  assign ctl_mode_w = ctl_q.mode;
  assign ctl_wrap_w = ctl_q.wrap_sel;
  assign flag_c     = flags_q.cy;
  assign flag_z     = flags_q.zr;
  assign flag_s     = flags_q.sg;
  assign flag_e     = flags_q.eq;
  assign flag_ov    = flags_q.ov;
  assign flag_gp    = flags_q.gp;

endmodule

// File: rtl/ptr_acc_file_chk.sv
module ptr_acc_file_chk #(
  parameter  int NUM_ACC = 16,
  parameter  int DATA_W  = 16,
  localparam int PTR_W   = $clog2(NUM_ACC)
) (
  input logic              clk,
  input logic              rst,
  input logic              alu_we,
  input logic [DATA_W-1:0] alu_result,
  input logic [3:0]        alu_fmask,
  input logic              alu_c,
  input logic              alu_ov,
  input logic              ptr_we,
  input logic [PTR_W-1:0]  ptr_wdata,
  input logic              gpf_we,
  input logic [1:0]        gpf_wdata,
  input logic [1:0]        ctl_mode,
  input logic [1:0]        ctl_wrap,
  input logic [PTR_W-1:0]  ptr_q,
  input logic [DATA_W-1:0] acc_q,
  input logic              flag_c,
  input logic              flag_z,
  input logic              flag_ov,
  input logic [1:0]        flag_gp
);

  // Window arithmetic by division, independent of the mask datapath
  function automatic logic [PTR_W-1:0] exp_step(input logic [PTR_W-1:0] p,
                                                input logic [1:0] w,
                                                input logic up);
    int size;
    int lo;
    int base;
    size = 2 << w;
    if (size > NUM_ACC) size = NUM_ACC;
    lo   = int'(p) % size;
    base = int'(p) - lo;
    lo   = up ? (lo + 1) % size : (lo + size - 1) % size;
    return PTR_W'(base + lo);
  endfunction

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (ptr_q == '0 && ctl_mode == 2'd0 && ctl_wrap == 2'd0 &&
             !flag_c && !flag_z && !flag_ov && flag_gp == 2'b00));

  // R7
  ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
    ptr_we |=> ptr_q == $past(ptr_wdata));

  // R4
  inc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (alu_we && !ptr_we && ctl_mode == 2'd1)
      |=> ptr_q == exp_step($past(ptr_q), $past(ctl_wrap), 1'b1));

  // R5
  dec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (alu_we && !ptr_we && ctl_mode == 2'd2)
      |=> ptr_q == exp_step($past(ptr_q), $past(ctl_wrap), 1'b0));

  // R12
  ptr_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!alu_we && !ptr_we) |=> $stable(ptr_q));

  // R2
  alu_dest_chk: assert property (@(posedge clk) disable iff (rst)
    (alu_we && !ptr_we && (ctl_mode == 2'd0 || ctl_mode == 2'd3))
      |=> acc_q == $past(alu_result));

  // R8
  carry_load_chk: assert property (@(posedge clk) disable iff (rst)
    (alu_we && alu_fmask[0]) |=> flag_c == $past(alu_c));

  // R8
  ovf_load_chk: assert property (@(posedge clk) disable iff (rst)
    (alu_we && alu_fmask[3]) |=> flag_ov == $past(alu_ov));

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !alu_we |=> $stable({flag_c, flag_ov}));

  // R10
  gp_load_chk: assert property (@(posedge clk) disable iff (rst)
    gpf_we |=> flag_gp == $past(gpf_wdata));

  // R10
  gp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !gpf_we |=> $stable(flag_gp));

endmodule

bind ptr_acc_file ptr_acc_file_chk #(.NUM_ACC(NUM_ACC), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .alu_we     (alu_we),
  .alu_result (alu_result),
  .alu_fmask  (alu_fmask),
  .alu_c      (alu_c),
  .alu_ov     (alu_ov),
  .ptr_we     (ptr_we),
  .ptr_wdata  (ptr_wdata),
  .gpf_we     (gpf_we),
  .gpf_wdata  (gpf_wdata),
  .ctl_mode   (ctl_mode_w),
  .ctl_wrap   (ctl_wrap_w),
  .ptr_q      (ptr_q),
  .acc_q      (acc_q),
  .flag_c     (flag_c),
  .flag_z     (flag_z),
  .flag_ov    (flag_ov),
  .flag_gp    (flag_gp)
);

// File: tb/ptr_acc_file_bench.sv
`timescale 1ns/1ps
module ptr_acc_file_bench;

  localparam int N  = 16;
  localparam int DW = 16;
  localparam int PW = 4;
  localparam int SIG_ACC = 0, SIG_PTR = 1, SIG_FLG = 2, SIG_RD = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          alu_we = 1'b0;
  logic [DW-1:0] alu_result = '0;
  logic [3:0]    alu_fmask = '0;
  logic          alu_c = 1'b0, alu_s = 1'b0, alu_e = 1'b0, alu_ov = 1'b0;
  logic          ptr_we = 1'b0;
  logic [PW-1:0] ptr_wdata = '0;
  logic          ctl_we = 1'b0;
  logic [3:0]    ctl_wdata = '0;
  logic          reg_we = 1'b0;
  logic [PW-1:0] reg_waddr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [PW-1:0] rd_addr = '0;
  logic          gpf_we = 1'b0;
  logic [1:0]    gpf_wdata = '0;
  logic [DW-1:0] acc_q, rd_data;
  logic [PW-1:0] ptr_q;
  logic          flag_c, flag_z, flag_s, flag_e, flag_ov;
  logic [1:0]    flag_gp;

  always #2.5 clk = ~clk;

  ptr_acc_file u_ptr_acc_file (
    .clk(clk), .rst(rst), .alu_we(alu_we), .alu_result(alu_result),
    .alu_fmask(alu_fmask), .alu_c(alu_c), .alu_s(alu_s), .alu_e(alu_e),
    .alu_ov(alu_ov), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .reg_we(reg_we),
    .reg_waddr(reg_waddr), .reg_wdata(reg_wdata), .rd_addr(rd_addr),
    .gpf_we(gpf_we), .gpf_wdata(gpf_wdata), .acc_q(acc_q), .ptr_q(ptr_q),
    .rd_data(rd_data), .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s),
    .flag_e(flag_e), .flag_ov(flag_ov), .flag_gp(flag_gp)
  );

  typedef struct {
    int          due;
    int          sig;
    logic [15:0] exp;
    logic [15:0] care;
    string       tag;
  } exp_item_t;

  exp_item_t   sb_q[$];
  int          cyc = 0;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  // Reference model state
  logic [DW-1:0] m_acc [N];
  int            m_ptr = 0, m_mode = 0, m_wrap = 0;
  bit            m_c, m_s, m_e, m_ov, m_known;
  bit [1:0]      m_gp;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops due items and compares against outputs
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      exp_item_t it;
      logic [15:0] act;
      it = sb_q.pop_front();
      case (it.sig)
        SIG_ACC: act = acc_q;
        SIG_PTR: act = 16'(ptr_q);
        SIG_FLG: act = {9'd0, flag_gp, flag_ov, flag_e, flag_s, flag_z, flag_c};
        default: act = rd_data;
      endcase
      n_cmp++;
      if ((act & it.care) !== (it.exp & it.care)) begin
        n_bad++;
        $display("FAIL %s sig%0d actual=%h expected=%h", it.tag, it.sig,
                 act & it.care, it.exp & it.care);
      end
    end
  end

  task automatic push(input int due, input int sig, input logic [15:0] e,
                      input logic [15:0] care, input string tag);
    exp_item_t it;
    it.due = due; it.sig = sig; it.exp = e; it.care = care; it.tag = tag;
    sb_q.push_back(it);
  endtask

  function automatic int model_step(input int p, input int wrap, input bit up);
    int size;
    size = 1 << (wrap + 1);
    if (size > N) size = N;
    if (up) return ((p & (size - 1)) == size - 1) ? p - (size - 1) : p + 1;
    else    return ((p & (size - 1)) == 0)        ? p + (size - 1) : p - 1;
  endfunction

  task automatic set_alu(input logic [15:0] r, input logic [3:0] m,
                         input bit c, input bit s, input bit e, input bit ov);
    alu_we = 1'b1; alu_result = r; alu_fmask = m;
    alu_c = c; alu_s = s; alu_e = e; alu_ov = ov;
  endtask
  task automatic set_ptr(input int v);
    ptr_we = 1'b1; ptr_wdata = PW'(v);
  endtask
  task automatic set_ctl(input int mode, input int wrap);
    ctl_we = 1'b1; ctl_wdata = {2'(wrap), 2'(mode)};
  endtask
  task automatic set_reg(input int idx, input logic [15:0] v);
    reg_we = 1'b1; reg_waddr = PW'(idx); reg_wdata = v;
  endtask
  task automatic set_gp(input logic [1:0] v);
    gpf_we = 1'b1; gpf_wdata = v;
  endtask

  // Driver: advances the model by one cycle, queues the expected outputs
  task automatic commit(input string tag, input bit chk_rd = 1'b0);
    logic [15:0] old_rd;
    int op;
    bit z;
    old_rd = m_acc[int'(rd_addr)];
    op = m_ptr;
    if (reg_we) m_acc[int'(reg_waddr)] = reg_wdata;
    if (alu_we) m_acc[op] = alu_result;
    if (ptr_we) m_ptr = int'(ptr_wdata);
    else if (alu_we && (m_mode == 1 || m_mode == 2)) m_ptr = model_step(m_ptr, m_wrap, m_mode == 1);
    if (ctl_we) begin m_mode = int'(ctl_wdata[1:0]); m_wrap = int'(ctl_wdata[3:2]); end
    if (alu_we) begin
      if (alu_fmask[0]) m_c = alu_c;
      if (alu_fmask[1]) m_s = alu_s;
      if (alu_fmask[2]) m_e = alu_e;
      if (alu_fmask[3]) m_ov = alu_ov;
    end
    if (gpf_we) m_gp = gpf_wdata;
    z = (m_acc[m_ptr] == 16'h0);
    push(cyc + 1, SIG_PTR, 16'(m_ptr), 16'hFFFF, tag);
    push(cyc + 1, SIG_FLG, {9'd0, m_gp, m_ov, m_e, m_s, z, m_c},
         m_known ? 16'hFFFF : 16'hFFFD, tag);
    if (m_known) push(cyc + 1, SIG_ACC, m_acc[m_ptr], 16'hFFFF, tag);
    if (chk_rd) push(cyc + 1, SIG_RD, old_rd, 16'hFFFF, tag);
    @(negedge clk);
    alu_we = 1'b0; ptr_we = 1'b0; ctl_we = 1'b0; reg_we = 1'b0; gpf_we = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state with reset still held
    push(cyc, SIG_PTR, 16'h0, 16'hFFFF, "R1");
    push(cyc, SIG_FLG, 16'h0, 16'hFFFF, "R1");
    @(negedge clk);
    rst = 1'b0;
    // R1: control cleared, so an ALU result leaves the pointer at 0
    set_alu(16'h0001, 4'h0, 0, 0, 0, 0); commit("R1");

    for (int i = 0; i < N; i++) begin
      set_reg(i, (i == 5) ? 16'h0000 : 16'(16'h0A00 + i * 16'h0111));
      commit("R3");
    end
    m_known = 1'b1;
    commit("R3");                             // R3: A0 shown
    set_ptr(5); commit("R9");                 // R9: zero register active
    set_ptr(3); commit("R3");                 // R3: follows pointer change

    // R8: masked flag loads
    set_alu(16'h1234, 4'hF, 1, 0, 1, 1); commit("R8");
    set_alu(16'h5678, 4'b0010, 0, 1, 0, 0); commit("R8");
    commit("R8");

    // R4 / R6: increment inside a 4-register window
    set_ctl(1, 1); commit("R12");
    set_ptr(6); commit("R7");
    for (int k = 0; k < 4; k++) begin
      set_alu(16'(16'h2000 + k), 4'h0, 0, 0, 0, 0); commit(k == 1 ? "R6" : "R4");
    end

    // R5: decrement inside an 8-register window
    set_ctl(2, 2); commit("R12");
    set_ptr(9); commit("R7");
    for (int k = 0; k < 3; k++) begin
      set_alu(16'(16'h3000 + k), 4'h0, 0, 0, 0, 0); commit("R5");
    end

    // R4: full 16 window wraps 15 -> 0
    set_ctl(1, 3); set_ptr(15); commit("R4");
    set_alu(16'h4000, 4'h0, 0, 0, 0, 0); commit("R4");
    // R5: 2-register window wraps 0 -> 1 -> 0
    set_ctl(2, 0); commit("R5");
    set_alu(16'h4100, 4'h0, 0, 0, 0, 0); commit("R5");
    set_alu(16'h4101, 4'h0, 0, 0, 0, 0); commit("R5");

    // R7: pointer write beats the step
    set_ctl(1, 3); commit("R12");
    set_alu(16'h5000, 4'h0, 0, 0, 0, 0); set_ptr(10); commit("R7");
    // R12: control write with ALU uses the old mode
    set_alu(16'h5100, 4'h0, 0, 0, 0, 0); set_ctl(2, 3); commit("R12");
    set_alu(16'h5200, 4'h0, 0, 0, 0, 0); commit("R12");
    // R4: mode 3 holds
    set_ctl(3, 3); commit("R4");
    set_alu(16'h5300, 4'h0, 0, 0, 0, 0); commit("R4");
    commit("R12");

    // R2: collisions with explicit writes
    set_ctl(0, 0); commit("R2");
    set_alu(16'hBEEF, 4'h0, 0, 0, 0, 0); set_reg(10, 16'h1111); commit("R2");
    set_alu(16'hCAFE, 4'h0, 0, 0, 0, 0); set_reg(2, 16'h2222); commit("R2");

    // R9: zero flag from ALU, explicit write and pointer change
    set_alu(16'h0000, 4'h0, 0, 0, 0, 0); commit("R9");
    set_reg(10, 16'h0042); commit("R9");
    set_ptr(5); commit("R9");

    // R10: general flags
    set_gp(2'b10); commit("R10");
    set_alu(16'h0001, 4'hF, 0, 0, 0, 0); commit("R10");
    set_gp(2'b01); commit("R10");

    // R11: read port, then read-before-write
    for (int i = 0; i < N; i++) begin
      rd_addr = PW'(i); commit("R11", 1'b1);
    end
    rd_addr = PW'(7); set_reg(7, 16'h7777); commit("R11", 1'b1);
    commit("R11", 1'b1);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule